// File: doc/BRIEF.md
# Pre-Trigger Event Capture Buffer

This block records a continuous stream of 14-bit samples into a 1024-entry ring memory on the sample clock. On a trigger it freezes one event. The event holds a programmable number of samples taken before the trigger, then the trigger sample, then the samples that follow it. A 3-bit code sets the total length of the event as a power of two.

Once the event is complete, it is streamed out on a separate, unrelated read clock. The output is one unbroken block, and a valid strobe stays high for every sample of it. The output side is a valid-only stream with no back-pressure: the consumer must accept one sample on every read clock cycle while `out_valid` is high. A sample is never repeated or held, so a consumer that cannot keep up loses data.

Two toggle handshakes cross the clock domains. One tells the read side that an event is ready. The other tells the capture side that readout has finished, so capture can re-arm.

Top module: `evtcap_top`

## Requirements
- R1: After reset, `out_valid` is 0 and no event is produced until a trigger is seen.
- R2: The trigger is synchronized and only its rising edge counts. Call E the first sample clock edge that sees `trig_in` high after it was low. The sample taken on edge E+2 is the trigger sample. Capture then writes one sample on every sample clock edge.
- R3: `size_code` selects the event length N: 0→16, 1→32, 2→64, 3→128, 4→256, 5→512, 6→1024, 7→1024. It is sampled at the trigger.
- R4: With a presample count P, the event holds the samples of edges E+2−P through E+2−P+N−1, in that order. P is sampled at the trigger.
- R5: If P ≥ N, P is treated as N−1, so the trigger sample is the last sample of the event.
- R6: Readout runs on `rd_clk`. `out_valid` is high for exactly N consecutive read clock cycles, and each of those cycles carries the next sample of the event.
- R7: A rising edge of `trig_in` is ignored while an event is being filled or read out. A trigger held high across re-arm does not start a new event.
- R8: After readout ends, capture re-arms by itself, and a later rising edge of the trigger produces a new, complete event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk | input | 1 | Sample clock |
| smp_rst_n | input | 1 | Active-low reset, sample domain |
| smp_data | input | 14 | Incoming sample |
| trig_in | input | 1 | Asynchronous trigger level |
| pre_cnt | input | 10 | Number of samples kept before the trigger sample |
| size_code | input | 3 | Encoded event length |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| out_data | output | 14 | Event sample on the read side |
| out_valid | output | 1 | High while `out_data` carries event data |

## Verification
The bench tests every size code against presample counts of zero, inside the range, exactly N−1, and above N. A design that got the clamp or the start address wrong would emit the right number of samples, but the data would be shifted relative to the trigger sample. It also fires triggers during the fill phase and during readout, and holds the trigger high across re-arm. A design that re-armed too early would emit a second, unrequested block, or would overwrite history while that history was still being read. Each block's length is counted, to catch an off-by-one at the last address or a gap in `out_valid`.

// File: rtl/evtcap_pkg.sv
package evtcap_pkg;
  typedef enum logic [1:0] {CAP_ARMED, CAP_FILL, CAP_HOLD} cap_state_e;

  // Event length for a size code; codes 6 and 7 share the largest length.
  function automatic int code_len(input logic [2:0] code, input int depth);
    int n;
    n = 16 << ((code == 3'd7) ? 3'd6 : code);
    if (n > depth) n = depth;
    return n;
  endfunction
endpackage

// File: rtl/evtcap_tsync.sv
module evtcap_tsync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      q      <= 1'b0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/evtcap_ram.sv
module evtcap_ram #(
  parameter int DW = 14,
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/evtcap_wr.sv
module evtcap_wr
  import evtcap_pkg::*;
#(
  parameter int AW = 10,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_in,
  input  logic [PW-1:0] pre_cnt,
  input  logic [2:0]    size_code,
  input  logic          done_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          rdy_tgl,
  output logic [AW-1:0] start_addr,
  output logic [AW:0]   ev_len
);
  localparam int DEPTH = 1 << AW;
  localparam int LW    = AW + 1;

  cap_state_e    state_q;
  logic          trig_s, trig_d, rise;
  logic          done_seen, done_evt;
  logic [AW-1:0] wp_q;
  logic [LW-1:0] remain_q, pre_q;
  logic [LW-1:0] len_now, pre_ext, pre_eff, post_left;

  evtcap_tsync u_trig_sync (.clk(clk), .rst_n(rst_n), .d(trig_in), .q(trig_s));

  assign rise      = trig_s & ~trig_d;
  assign done_evt  = done_s ^ done_seen;
  assign len_now   = LW'(code_len(size_code, DEPTH));
  assign pre_ext   = LW'(pre_cnt);
  assign pre_eff   = (pre_ext >= len_now) ? (len_now - LW'(1)) : pre_ext;
  assign post_left = len_now - pre_eff - LW'(1);
  assign we        = (state_q != CAP_HOLD);
  assign waddr     = wp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CAP_ARMED;
      trig_d     <= 1'b0;
      done_seen  <= 1'b0;
      wp_q       <= '0;
      remain_q   <= '0;
      pre_q      <= '0;
      rdy_tgl    <= 1'b0;
      start_addr <= '0;
      ev_len     <= LW'(16);
    end else begin
      trig_d    <= trig_s;
      done_seen <= done_s;
      if (we) wp_q <= wp_q + AW'(1);
      unique case (state_q)
        CAP_ARMED: if (rise) begin
          start_addr <= wp_q - pre_eff[AW-1:0];
          ev_len     <= len_now;
          pre_q      <= pre_eff;
          remain_q   <= post_left;
          if (post_left == '0) begin
            state_q <= CAP_HOLD;
            rdy_tgl <= ~rdy_tgl;
          end else begin
            state_q <= CAP_FILL;
          end
        end
        CAP_FILL: begin
          remain_q <= remain_q - LW'(1);
          if (remain_q == LW'(1)) begin
            state_q <= CAP_HOLD;
            rdy_tgl <= ~rdy_tgl;
          end
        end
        CAP_HOLD: if (done_evt) state_q <= CAP_ARMED;
        default: state_q <= CAP_ARMED;
      endcase
    end
  end

  // Memory must stay frozen while an event waits for or undergoes readout.
  assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAP_HOLD && $past(state_q) == CAP_HOLD) |-> $stable(wp_q));
  // The applied presample count is always below the captured length.
  assert_pre_clamped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != CAP_ARMED) |-> (pre_q < ev_len));
  // No second ready toggle until readout has returned.
  assert_single_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAP_HOLD && $past(state_q) == CAP_HOLD) |-> $stable(rdy_tgl));
endmodule

// File: rtl/evtcap_rd.sv
module evtcap_rd #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rdy_s,
  input  logic [AW-1:0] start_addr,
  input  logic [AW:0]   ev_len,
  output logic [AW-1:0] raddr,
  output logic          valid,
  output logic          done_tgl
);
  localparam int LW = AW + 1;

  logic          rdy_seen, load, busy_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] cnt_q, len_q, run_q;

  assign load  = rdy_s ^ rdy_seen;
  assign raddr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_seen <= 1'b0;
      busy_q   <= 1'b0;
      addr_q   <= '0;
      cnt_q    <= '0;
      len_q    <= LW'(16);
      valid    <= 1'b0;
      done_tgl <= 1'b0;
      run_q    <= '0;
    end else begin
      rdy_seen <= rdy_s;
      valid    <= busy_q;
      run_q    <= valid ? run_q + LW'(1) : '0;
      if (busy_q) begin
        addr_q <= addr_q + AW'(1);
        cnt_q  <= cnt_q + LW'(1);
        if (cnt_q == len_q - LW'(1)) begin
          busy_q   <= 1'b0;
          done_tgl <= ~done_tgl;
        end
      end else if (load) begin
        busy_q <= 1'b1;
        addr_q <= start_addr;
        cnt_q  <= '0;
        len_q  <= ev_len;
      end
    end
  end

  // A block of valid data is exactly one event long.
  assert_run_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> (run_q == len_q));
  // A new event never arrives while the previous one is still streaming.
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);
endmodule

// File: rtl/evtcap_top.sv
module evtcap_top #(
  parameter int DW = 14,
  parameter int AW = 10,
  parameter int PW = 10
) (
  input  logic          smp_clk,
  input  logic          smp_rst_n,
  input  logic [DW-1:0] smp_data,
  input  logic          trig_in,
  input  logic [PW-1:0] pre_cnt,
  input  logic [2:0]    size_code,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);
  logic          we, rdy_tgl, rdy_s, done_tgl, done_s;
  logic [AW-1:0] waddr, raddr, start_addr;
  logic [AW:0]   ev_len;

  evtcap_wr #(.AW(AW), .PW(PW)) u_wr (
    .clk(smp_clk), .rst_n(smp_rst_n), .trig_in(trig_in), .pre_cnt(pre_cnt),
    .size_code(size_code), .done_s(done_s), .we(we), .waddr(waddr),
    .rdy_tgl(rdy_tgl), .start_addr(start_addr), .ev_len(ev_len)
  );

  evtcap_tsync u_rdy_sync  (.clk(rd_clk),  .rst_n(rd_rst_n),  .d(rdy_tgl),  .q(rdy_s));
  evtcap_tsync u_done_sync (.clk(smp_clk), .rst_n(smp_rst_n), .d(done_tgl), .q(done_s));

  evtcap_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(smp_clk), .we(we), .waddr(waddr), .wdata(smp_data),
    .rclk(rd_clk), .raddr(raddr), .rdata(out_data)
  );

  evtcap_rd #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rdy_s(rdy_s), .start_addr(start_addr),
    .ev_len(ev_len), .raddr(raddr), .valid(out_valid), .done_tgl(done_tgl)
  );
endmodule

// File: tb/tb_evtcap_top.sv
module tb_evtcap_top;
  logic        smp_clk = 0, rd_clk = 0;
  logic        smp_rst_n = 0, rd_rst_n = 0;
  logic [13:0] smp_data = '0;
  logic        trig_in = 0;
  logic [9:0]  pre_cnt = '0;
  logic [2:0]  size_code = '0;
  logic [13:0] out_data;
  logic        out_valid;

  int nchk = 0, nfail = 0;
  int ecnt = 0, run = 0, blocks = 0, exp_blocks = 0;
  logic [13:0] expq[$];
  int lenq[$];

  evtcap_top dut (.*);

  always #10 smp_clk = ~smp_clk;   // 50 MHz
  always #13 rd_clk  = ~rd_clk;

  function automatic logic [13:0] fv(input int k);
    return 14'((k * 37 + 5) & 16'h3FFF);
  endfunction

  always @(posedge smp_clk) ecnt++;
  always @(negedge smp_clk) smp_data = fv(ecnt + 1);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference comparison on every read clock (R6, R4).
  always @(negedge rd_clk) begin
    if (rd_rst_n) begin
      if (out_valid) begin
        if (expq.size() == 0) chk(0, "R7 unexpected valid", 1, 0);
        else begin
          chk(out_data == expq[0], "R4 event data", out_data, expq[0]);
          void'(expq.pop_front());
        end
        run++;
      end else if (run != 0) begin
        blocks++;
        if (lenq.size() == 0) chk(0, "R6 block without event", run, 0);
        else chk(run == lenq.pop_front(), "R6 block length", run, 0);
        run = 0;
      end
    end
  end

  task automatic wait_smp(input int n);
    for (int i = 0; i < n; i++) @(negedge smp_clk);
  endtask

  task automatic wait_drain();
    while (expq.size() != 0 || lenq.size() != 0 || run != 0) @(negedge rd_clk);
  endtask

  // Fires a trigger and queues the expected event (R2..R5).
  task automatic fire(input int code, input int p, input int hold);
    int n, pe, e0;
    n  = 16 << ((code == 7) ? 6 : code);
    pe = (p >= n) ? n - 1 : p;
    size_code = 3'(code);
    pre_cnt   = 10'(p);
    wait_smp(3);
    @(negedge smp_clk);
    trig_in = 1;
    e0 = ecnt + 1;
    for (int i = 0; i < n; i++) expq.push_back(fv(e0 + 2 - pe + i));
    lenq.push_back(n);
    exp_blocks++;
    wait_smp(hold);
    trig_in = 0;
  endtask

  task automatic one_event(input int code, input int p);
    fire(code, p, 4);
    wait_drain();
    wait_smp(1100);   // re-arm (R8) and refill history
  endtask

  initial begin
    wait_smp(5);
    smp_rst_n = 1;
    rd_rst_n  = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge rd_clk);
      chk(out_valid == 0, "R1 idle after reset", out_valid, 0);
    end
    wait_smp(1100);

    one_event(0, 5);      // R3 R4
    one_event(1, 0);      // R4 no history
    one_event(2, 63);     // R5 boundary P=N-1
    one_event(3, 200);    // R5 clamp
    one_event(4, 100);    // R3
    one_event(5, 511);    // R5 boundary
    one_event(6, 1023);   // R4 full history
    one_event(7, 1000);   // R3 code 7 length
    one_event(0, 1023);   // R5 clamp smallest

    // R7: second edge during fill is ignored
    fire(6, 0, 3);
    wait_smp(3);
    trig_in = 1; wait_smp(3); trig_in = 0;
    wait_drain();
    wait_smp(1100);

    // R7: edge during readout is ignored
    fire(6, 10, 3);
    while (!out_valid) @(negedge rd_clk);
    @(negedge smp_clk);
    trig_in = 1; wait_smp(3); trig_in = 0;
    wait_drain();
    wait_smp(1500);
    chk(blocks == exp_blocks, "R7 no extra block", blocks, exp_blocks);

    // R7: trigger held high across re-arm gives a single event
    fire(4, 20, 1);
    trig_in = 1;
    wait_drain();
    wait_smp(1500);
    chk(blocks == exp_blocks && out_valid == 0, "R7 held trigger", blocks, exp_blocks);
    trig_in = 0;
    wait_smp(1100);

    // R8: capture still works after all the ignored triggers
    one_event(2, 7);
    chk(blocks == exp_blocks, "R8 re-armed event count", blocks, exp_blocks);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    wait_smp(150000);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired, actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule